// File: doc/BRIEF.md
# Table-Encoded Gated Clock Divider

The block derives a slower clock from its parent clock by counting parent cycles. A 4-bit select code picks the divide ratio from a fixed, sparse table that mixes odd and non-power-of-two ratios (3, 4, 6, 8, 12, 16, 18, 24, 36, 48). A disable bit in the same configuration word stops the output. Software-side logic writes one word and reads it back over a plain single-cycle write strobe and a continuously driven read value.

The divided output is produced by a register clocked by the parent clock. Every period starts with the high phase: the output stays high for floor(N/2) parent cycles and low for the rest, so even ratios give a 50% duty cycle and odd ratios are one cycle short on the high side. A new ratio and a change of the disable bit are both taken up only at the last cycle of the current period, so every period on the output is complete and no shortened phase appears. A code with no table entry leaves the divider running at the last valid ratio. A build-time option adds a divide-by-2 entry on code 0 for a faster output.

Top module: `tbl_clk_div`

## Requirements
- R1: The select code in bits [3:0] of the configuration word sets the output period to N parent cycles, with code 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36 and 11→48.
- R2: Codes 9, 12, 13, 14 and 15 (and code 0 when the short option is off) select no ratio; the divider keeps running at the last valid ratio.
- R3: With the parameter HAS_SHORT set to 1, code 0 selects a ratio of 2 (output high 1 cycle, low 1 cycle).
- R4: Each output period starts high; the output is high for floor(N/2) parent cycles and low for the remaining N - floor(N/2) cycles.
- R5: A new ratio is adopted only at the end of the current period; the period in progress when the code is written completes with the old ratio.
- R6: Bit 8 of the configuration word set to 1 disables the output and 0 enables it; the change takes effect at the end of the current period, after which a disabled output stays low and an enabled one starts a full period.
- R7: After reset the code is 1 (ratio 3), bit 8 is 0, the output is low, and the first period starts high on the first parent clock edge after reset is released.
- R8: A write with cfg_we high updates the word on the next clock edge; cfg_rdata returns the code in bits [3:0], the disable flag in bit 8 and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| div_clk | output | 1 | Divided, gateable clock output |

## Verification
The assertions take for granted that the parent clock runs continuously, that reset is held across at least one edge, and that the configuration word changes only through cfg_we, so the counter, the active ratio and the run flag evolve only at parent edges. They also assume nothing but whole periods exist, which holds because ratio and run changes are confined to the counter's wrap cycle. The stimulus drives writes at falling edges, one word per strobe, and settles each new ratio over a full period before measuring, so every sample the bench takes lies inside a complete period.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  parameter int CODE_W   = 4;
  parameter int DIV_W    = 6;
  parameter int REG_W    = 32;
  parameter int GATE_POS = 8;
  parameter int RST_CODE = 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DIV_W-1:0]  ratio_t;

  // Ratio of the base table; zero marks a code with no ratio.
  function automatic ratio_t base_ratio(input code_t c);
    case (c)
      code_t'(1):  return ratio_t'(3);
      code_t'(2):  return ratio_t'(4);
      code_t'(3):  return ratio_t'(6);
      code_t'(4):  return ratio_t'(8);
      code_t'(5):  return ratio_t'(12);
      code_t'(6):  return ratio_t'(16);
      code_t'(7):  return ratio_t'(18);
      code_t'(8):  return ratio_t'(24);
      code_t'(10): return ratio_t'(36);
      code_t'(11): return ratio_t'(48);
      default:     return ratio_t'(0);
    endcase
  endfunction

  function automatic logic is_table_ratio(input ratio_t r);
    case (r)
      ratio_t'(2), ratio_t'(3), ratio_t'(4), ratio_t'(6), ratio_t'(8),
      ratio_t'(12), ratio_t'(16), ratio_t'(18), ratio_t'(24),
      ratio_t'(36), ratio_t'(48): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tcd_cfg_reg.sv
module tcd_cfg_reg #(
  parameter int REG_W    = tcd_pkg::REG_W,
  parameter int CODE_W   = tcd_pkg::CODE_W,
  parameter int GATE_POS = tcd_pkg::GATE_POS,
  parameter int RST_CODE = tcd_pkg::RST_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [CODE_W-1:0] code,
  output logic              gate_off,
  output logic [REG_W-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= CODE_W'(RST_CODE);
      gate_off <= 1'b0;
    end else if (we) begin
      code     <= wdata[CODE_W-1:0];
      gate_off <= wdata[GATE_POS];
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[CODE_W-1:0]   = code;
    rdata[GATE_POS]     = gate_off;
  end
endmodule

// File: rtl/tcd_ratio_lut.sv
module tcd_ratio_lut #(
  parameter int CODE_W    = tcd_pkg::CODE_W,
  parameter int DIV_W     = tcd_pkg::DIV_W,
  parameter bit HAS_SHORT = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  ratio,
  output logic              valid
);
  logic [DIV_W-1:0] base;

  always_comb base = DIV_W'(tcd_pkg::base_ratio(tcd_pkg::code_t'(code)));

  generate
    if (HAS_SHORT) begin : g_short
      always_comb begin
        if (code == '0) ratio = DIV_W'(2);
        else            ratio = base;
        valid = (ratio != '0);
      end
    end else begin : g_base
      always_comb begin
        ratio = base;
        valid = (base != '0);
      end
    end
  endgenerate
endmodule

// File: rtl/tcd_div_core.sv
module tcd_div_core #(
  parameter int DIV_W     = tcd_pkg::DIV_W,
  parameter int RST_RATIO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] new_ratio,
  input  logic             new_valid,
  input  logic             gate_off,
  output logic             div_clk,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] active,
  output logic             run
);
  logic             wrap;
  logic [DIV_W-1:0] cnt_n;
  logic [DIV_W-1:0] act_n;
  logic             run_n;
  logic             out_n;

  always_comb begin
    wrap  = (cnt == active - DIV_W'(1));
    cnt_n = wrap ? '0 : cnt + DIV_W'(1);
    act_n = (wrap && new_valid) ? new_ratio : active;
    run_n = wrap ? ~gate_off : run;
    out_n = run_n && (cnt_n < (act_n >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= DIV_W'(RST_RATIO - 1);
      active  <= DIV_W'(RST_RATIO);
      run     <= 1'b1;
      div_clk <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      active  <= act_n;
      run     <= run_n;
      div_clk <= out_n;
    end
  end
endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div #(
  parameter int REG_W     = tcd_pkg::REG_W,
  parameter int CODE_W    = tcd_pkg::CODE_W,
  parameter int DIV_W     = tcd_pkg::DIV_W,
  parameter int GATE_POS  = tcd_pkg::GATE_POS,
  parameter int RST_CODE  = tcd_pkg::RST_CODE,
  parameter bit HAS_SHORT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             div_clk
);
  localparam int RST_RATIO =
    int'(tcd_pkg::base_ratio(tcd_pkg::code_t'(RST_CODE)));

  logic [CODE_W-1:0] code;
  logic              gate_off;
  logic [DIV_W-1:0]  lut_ratio;
  logic              lut_valid;
  logic [DIV_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  active_q;
  logic              run_q;

  tcd_cfg_reg #(
    .REG_W(REG_W), .CODE_W(CODE_W), .GATE_POS(GATE_POS), .RST_CODE(RST_CODE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .code(code), .gate_off(gate_off), .rdata(cfg_rdata)
  );

  tcd_ratio_lut #(
    .CODE_W(CODE_W), .DIV_W(DIV_W), .HAS_SHORT(HAS_SHORT)
  ) u_lut (
    .code(code), .ratio(lut_ratio), .valid(lut_valid)
  );

  tcd_div_core #(
    .DIV_W(DIV_W), .RST_RATIO(RST_RATIO)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .new_ratio(lut_ratio), .new_valid(lut_valid),
    .gate_off(gate_off), .div_clk(div_clk), .cnt(cnt_q),
    .active(active_q), .run(run_q)
  );
endmodule

// File: rtl/tcd_chk.sv
module tcd_chk #(
  parameter int REG_W    = tcd_pkg::REG_W,
  parameter int CODE_W   = tcd_pkg::CODE_W,
  parameter int DIV_W    = tcd_pkg::DIV_W,
  parameter int GATE_POS = tcd_pkg::GATE_POS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             div_clk,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] active,
  input logic             run
);
  localparam logic [REG_W-1:0] RD_MASK =
    (REG_W'(1) << GATE_POS) | ((REG_W'(1) << CODE_W) - REG_W'(1));

  // R1 / R2: the running ratio is always one from the table
  a_r2_ratio_from_table: assert property (@(posedge clk) disable iff (!rst_n)
    tcd_pkg::is_table_ratio(tcd_pkg::ratio_t'(active)) && (cnt < active));

  // R4: a period starts high at count zero
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> (cnt == '0));

  // R4: the high phase ends after floor(N/2) cycles
  a_r4_fall_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk) |-> (cnt == (active >> 1)));

  // R5: the ratio only changes where the previous count wrapped
  a_r5_switch_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> ($past(cnt) == $past(active) - DIV_W'(1)));

  // R6: a stopped divider keeps its output low
  a_r6_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !div_clk);

  // R6: the run flag only changes at the start of a period
  a_r6_gate_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> (cnt == '0));

  // R8: the written fields read back on the next cycle
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & RD_MASK)));
endmodule

bind tbl_clk_div tcd_chk #(
  .REG_W(REG_W), .CODE_W(CODE_W), .DIV_W(DIV_W), .GATE_POS(GATE_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .div_clk(div_clk), .cnt(cnt_q),
  .active(active_q), .run(run_q)
);

// File: tb/tbl_clk_div_tb.sv
module tbl_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        out_a, out_b;

  int checks = 0;
  int bad = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  tbl_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_a), .div_clk(out_a)
  );

  tbl_clk_div #(.HAS_SHORT(1'b1)) u_dut_short (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_b), .div_clk(out_b)
  );

  // code, expected ratio (reserved codes expect the ratio held from before)
  localparam int NV = 17;
  localparam int VC[NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 10, 11, 9, 12, 2, 13, 14, 15, 0};
  localparam int VR[NV] = '{3, 4, 6, 8, 12, 16, 18, 24, 36, 48, 48, 48, 4, 4, 4, 4, 4};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input bit sel);
    return sel ? out_b : out_a;
  endfunction

  task automatic write_word(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Ends at the falling clock edge where the output has just risen.
  task automatic wait_rise(input bit sel);
    int n = 0;
    while (pick(sel) !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    while (pick(sel) !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) timed_out = 1'b1;
  endtask

  // Measure one period starting at a rise; ends at the next rise.
  task automatic measure(input bit sel, output int hi, output int lo);
    wait_rise(sel);
    hi = 0; lo = 0;
    while (pick(sel) === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    while (pick(sel) === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int hi, lo, n;
    // R7: reset state
    @(negedge clk); @(negedge clk);
    check(out_a == 1'b0, "R7 output low in reset", out_a, 0);
    check(rdata_a == 32'h1, "R7 reset word", rdata_a, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_a == 1'b1, "R7 first edge starts high", out_a, 1);
    hi = 1; lo = 0;
    @(negedge clk);
    while (out_a === 1'b1 && hi < 10) begin hi++; @(negedge clk); end
    while (out_a === 1'b0 && lo < 10) begin lo++; @(negedge clk); end
    check(hi == 1, "R7 first period high", hi, 1);
    check(lo == 2, "R7 first period low", lo, 2);

    // R1 / R2 / R4: table walk
    for (int i = 0; i < NV; i++) begin
      write_word(32'(VC[i]));
      measure(1'b0, hi, lo);
      measure(1'b0, hi, lo);
      check(hi == VR[i] / 2, $sformatf("R1 R4 code %0d high", VC[i]), hi, VR[i] / 2);
      check(lo == VR[i] - VR[i] / 2, $sformatf("R1 R2 code %0d low", VC[i]), lo, VR[i] - VR[i] / 2);
    end

    // R3: short option gives ratio 2 on code 0 (last vector wrote 0)
    measure(1'b1, hi, lo);
    check(hi == 1 && lo == 1, "R3 short ratio period", hi + lo, 2);
    check(hi == 1, "R3 short ratio high", hi, 1);

    // R5: code written at period start; current period keeps old ratio
    write_word(32'h4);
    measure(1'b0, hi, lo);
    measure(1'b0, hi, lo);
    cfg_we = 1'b1; cfg_wdata = 32'hB;
    @(negedge clk);
    cfg_we = 1'b0;
    n = 1;
    while (out_a === 1'b1 && n < 100) begin n++; @(negedge clk); end
    while (out_a === 1'b0 && n < 100) begin n++; @(negedge clk); end
    check(n == 8, "R5 old period completes", n, 8);
    hi = 0; lo = 0;
    while (out_a === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    while (out_a === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check(hi + lo == 48, "R5 next period uses new ratio", hi + lo, 48);

    // R6: disable at period start; current period completes, then low
    write_word(32'h2);
    measure(1'b0, hi, lo);
    measure(1'b0, hi, lo);
    cfg_we = 1'b1; cfg_wdata = 32'h102;
    @(negedge clk);
    cfg_we = 1'b0;
    hi = 1;
    while (out_a === 1'b1 && hi < 10) begin hi++; @(negedge clk); end
    check(hi == 2, "R6 gated period high phase intact", hi, 2);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      if (out_a !== 1'b0) n++;
      @(negedge clk);
    end
    check(n == 0, "R6 output held low while disabled", n, 0);
    write_word(32'h2);
    measure(1'b0, hi, lo);
    check(hi == 2 && lo == 2, "R6 full period after enable", hi * 10 + lo, 22);

    // R8: readback of all-ones write, then reserved code + disabled
    write_word(32'hFFFF_FFFF);
    check(rdata_a == 32'h10F, "R8 readback masks other bits", rdata_a, 32'h10F);
    for (int k = 0; k < 10; k++) @(negedge clk);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (out_a !== 1'b0) n++;
      @(negedge clk);
    end
    check(n == 0, "R6 R8 disabled via full word", n, 0);
    write_word(32'h0000_0105);
    check(rdata_a == 32'h105, "R8 readback code and flag", rdata_a, 32'h105);
    write_word(32'h1);
    check(rdata_a == 32'h1, "R8 readback enabled", rdata_a, 1);
    measure(1'b0, hi, lo);
    measure(1'b0, hi, lo);
    check(hi == 1 && lo == 2, "R1 R4 odd ratio 3 duty", hi * 10 + lo, 12);

    if (timed_out) check(1'b0, "R4 measurement timeout", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule